// File: doc/BRIEF.md
# Inbound Packet Acknowledge Controller

This block sits on the receive side of a serial packet link. It sees one completion report for each inbound packet. The report carries the packet's 5-bit ackID, a CRC-error flag and the payload length in bytes. From each report the block decides whether the packet is acknowledged as accepted, asked to be retried, or refused. It passes that decision to the control symbol generator, together with the receiver's current free-buffer count. It also raises a one-cycle discard pulse toward the user side for every packet that is not accepted.

A packet is in error when its ackID is not the one the receiver expects, when its CRC failed, or when its payload is longer than the maximum. Any such error moves the receiver at once into an input error-stopped state. That first error produces a single refusal carrying a cause code. While the receiver is stopped, every further packet is dropped silently. Only a restart-from-error symbol from the link partner ends the state. The expected ackID moves forward only on accepted packets.

Top module: `ack_inbound`

## Requirements
- R1: After reset, expAckId is 0, errStopped is 0, and ackValid and discardPulse are low.
- R2: A report with the expected ackID, no CRC error, pktLen at most MAX_PAYLOAD and freeBufs non-zero gives an acknowledgement one cycle later. The acknowledgement has ackValid=1, ackKind=0 (accepted) and ackId equal to the packet's ackID. expAckId then increments modulo 32, so 31 is followed by 0.
- R3: A report that would be accepted but arrives while freeBufs is 0 gives ackKind=1 (retry) with the packet's ackID and a discard pulse. expAckId is unchanged and errStopped stays 0.
- R4: A report whose ackID differs from expAckId gives ackKind=2 (not accepted) with ackCause=1, ackId equal to expAckId and a discard pulse, and sets errStopped.
- R5: A report with the right ackID and the CRC flag set gives ackKind=2 with ackCause=2. When several errors are present, the cause is chosen in the order ackID (1), then CRC (2), then overrun (3).
- R6: pktLen greater than MAX_PAYLOAD (256) is an overrun and gives ackKind=2 with ackCause=3. A length of exactly 256 is not an error.
- R7: While errStopped is 1, every report gives a discard pulse and no acknowledgement, and expAckId does not change. An error episode therefore produces exactly one not-accepted acknowledgement.
- R8: restartIn clears errStopped one cycle later. When errStopped is 0, restartIn has no effect. A report arriving in the same cycle as the restart is still discarded.
- R9: Every acknowledgement carries in ackBufs the value freeBufs had in the cycle of the report. ackCause is 0 for accepted and retry acknowledgements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktDone | input | 1 | Completion report valid for one cycle |
| pktAckId | input | 5 | ackID of the completed packet |
| pktCrcErr | input | 1 | Packet CRC check failed |
| pktLen | input | 10 | Payload length in bytes |
| freeBufs | input | 5 | Free receive packet buffers |
| restartIn | input | 1 | Restart-from-error symbol received |
| ackValid | output | 1 | Acknowledge request valid |
| ackKind | output | 2 | 0 accepted, 1 retry, 2 not accepted |
| ackId | output | 5 | ackID carried by the request |
| ackCause | output | 2 | Refusal cause: 1 ackID, 2 CRC, 3 overrun |
| ackBufs | output | 5 | Buffer count reported in the request |
| discardPulse | output | 1 | One-cycle discard toward user side |
| errStopped | output | 1 | Input error-stopped state |
| expAckId | output | 5 | Next expected ackID |

## Verification
The hardest situation to reach is a report that arrives while the receiver is already stopped, in the same cycle as a restart, and only after the expected ackID has wrapped past 31. Random stimulus mostly sends packets with the matching ackID so that accepts pile up and force the wrap. It mixes in rare errors, zero-buffer cycles and frequent restarts, so stopped episodes are entered and left many times. Directed steps then place a packet exactly on a restart cycle, place a restart outside a stopped episode, and use lengths of 256 and 257.

// File: rtl/ack_inbound_pkg.sv
package ack_inbound_pkg;

  typedef enum logic [1:0] {
    KIND_ACCEPT = 2'd0,
    KIND_RETRY  = 2'd1,
    KIND_REJECT = 2'd2
  } ackKindT;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_ID   = 2'd1,
    CAUSE_CRC  = 2'd2,
    CAUSE_LEN  = 2'd3
  } causeT;

  // strobes from control to datapath
  typedef struct packed {
    logic  accept;
    logic  retry;
    logic  reject;
    logic  discard;
    causeT cause;
  } strobeT;

endpackage

// File: rtl/ack_classify.sv
module ack_classify #(
  parameter int ID_W        = 5,
  parameter int LEN_W       = 10,
  parameter int MAX_PAYLOAD = 256
) (
  input  logic [ID_W-1:0]           pktAckId,
  input  logic [ID_W-1:0]           expAckId,
  input  logic                      pktCrcErr,
  input  logic [LEN_W-1:0]          pktLen,
  output ack_inbound_pkg::causeT    cause
);
  import ack_inbound_pkg::*;

  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_PAYLOAD);

  logic idBad, lenBad;

  assign idBad  = (pktAckId != expAckId);
  assign lenBad = (pktLen > LEN_LIMIT);

  // fixed priority: ackID, then CRC, then overrun
  always_comb begin
    if (idBad)          cause = CAUSE_ID;
    else if (pktCrcErr) cause = CAUSE_CRC;
    else if (lenBad)    cause = CAUSE_LEN;
    else                cause = CAUSE_NONE;
  end

endmodule

// File: rtl/ack_control.sv
module ack_control #(
  parameter int BUF_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pktDone,
  input  logic                    restartIn,
  input  logic [BUF_W-1:0]        freeBufs,
  input  ack_inbound_pkg::causeT  cause,
  output ack_inbound_pkg::strobeT strb,
  output logic                    stopped
);
  import ack_inbound_pkg::*;

  logic stoppedNext;
  logic noBufs;

  assign noBufs = (freeBufs == '0);

  always_comb begin
    strb = '0;
    strb.cause = CAUSE_NONE;
    if (pktDone) begin
      if (stopped) begin
        strb.discard = 1'b1;
      end else if (cause != CAUSE_NONE) begin
        strb.reject  = 1'b1;
        strb.discard = 1'b1;
        strb.cause   = cause;
      end else if (noBufs) begin
        strb.retry   = 1'b1;
        strb.discard = 1'b1;
      end else begin
        strb.accept  = 1'b1;
      end
    end
  end

  always_comb begin
    if (stopped) stoppedNext = !restartIn;
    else         stoppedNext = strb.reject;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stopped <= 1'b0;
    else       stopped <= stoppedNext;
  end

  assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.accept, strb.retry, strb.reject}));

  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    stopped && !restartIn |=> stopped);

  assert_stop_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    stopped && pktDone |-> strb.discard && !strb.accept && !strb.retry && !strb.reject);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopped && restartIn |=> !stopped);

  assert_enter_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> stopped);

endmodule

// File: rtl/ack_datapath.sv
module ack_datapath #(
  parameter int ID_W  = 5,
  parameter int BUF_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ack_inbound_pkg::strobeT strb,
  input  logic [ID_W-1:0]         pktAckId,
  input  logic [BUF_W-1:0]        freeBufs,
  output logic [ID_W-1:0]         expAckId,
  output logic                    ackValid,
  output logic [1:0]              ackKind,
  output logic [ID_W-1:0]         ackId,
  output logic [1:0]              ackCause,
  output logic [BUF_W-1:0]        ackBufs,
  output logic                    discardPulse
);
  import ack_inbound_pkg::*;

  logic anyAck;
  ackKindT kindNext;

  assign anyAck = strb.accept | strb.retry | strb.reject;

  always_comb begin
    if (strb.reject)     kindNext = KIND_REJECT;
    else if (strb.retry) kindNext = KIND_RETRY;
    else                 kindNext = KIND_ACCEPT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expAckId <= '0;
    end else if (strb.accept) begin
      expAckId <= expAckId + ID_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid     <= 1'b0;
      ackKind      <= KIND_ACCEPT;
      ackId        <= '0;
      ackCause     <= CAUSE_NONE;
      ackBufs      <= '0;
      discardPulse <= 1'b0;
    end else begin
      ackValid     <= anyAck;
      discardPulse <= strb.discard;
      if (anyAck) begin
        ackKind  <= kindNext;
        ackId    <= strb.reject ? expAckId : pktAckId;
        ackCause <= strb.cause;
        ackBufs  <= freeBufs;
      end
    end
  end

  assert_exp_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> expAckId == $past(expAckId) + ID_W'(1));

  assert_exp_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> $stable(expAckId));

  assert_refuse_discard_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && ackKind != KIND_ACCEPT |-> discardPulse);

  assert_accept_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && ackKind == KIND_ACCEPT |-> !discardPulse);

endmodule

// File: rtl/ack_inbound.sv
module ack_inbound #(
  parameter int ID_W        = 5,
  parameter int BUF_W       = 5,
  parameter int LEN_W       = 10,
  parameter int MAX_PAYLOAD = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pktDone,
  input  logic [ID_W-1:0]  pktAckId,
  input  logic             pktCrcErr,
  input  logic [LEN_W-1:0] pktLen,
  input  logic [BUF_W-1:0] freeBufs,
  input  logic             restartIn,
  output logic             ackValid,
  output logic [1:0]       ackKind,
  output logic [ID_W-1:0]  ackId,
  output logic [1:0]       ackCause,
  output logic [BUF_W-1:0] ackBufs,
  output logic             discardPulse,
  output logic             errStopped,
  output logic [ID_W-1:0]  expAckId
);
  import ack_inbound_pkg::*;

  causeT  cause;
  strobeT strb;

  ack_classify #(.ID_W(ID_W), .LEN_W(LEN_W), .MAX_PAYLOAD(MAX_PAYLOAD)) uClassify (
    .pktAckId (pktAckId),
    .expAckId (expAckId),
    .pktCrcErr(pktCrcErr),
    .pktLen   (pktLen),
    .cause    (cause)
  );

  ack_control #(.BUF_W(BUF_W)) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .pktDone  (pktDone),
    .restartIn(restartIn),
    .freeBufs (freeBufs),
    .cause    (cause),
    .strb     (strb),
    .stopped  (errStopped)
  );

  ack_datapath #(.ID_W(ID_W), .BUF_W(BUF_W)) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .pktAckId    (pktAckId),
    .freeBufs    (freeBufs),
    .expAckId    (expAckId),
    .ackValid    (ackValid),
    .ackKind     (ackKind),
    .ackId       (ackId),
    .ackCause    (ackCause),
    .ackBufs     (ackBufs),
    .discardPulse(discardPulse)
  );

endmodule

// File: tb/ack_inbound_test.sv
module ack_inbound_test;

  logic clk = 1'b0;
  logic rstN;
  logic pktDone, pktCrcErr, restartIn;
  logic [4:0] pktAckId, freeBufs;
  logic [9:0] pktLen;
  logic ackValid, discardPulse, errStopped;
  logic [1:0] ackKind, ackCause;
  logic [4:0] ackId, ackBufs, expAckId;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [4:0] mExp;
  logic       mStop;
  // pending expectation
  logic       pend;
  logic       eValid, eDisc;
  logic [1:0] eKind, eCause;
  logic [4:0] eId, eBufs;
  string      eTag;

  always #2.5 clk = ~clk;

  ack_inbound uut (
    .clk(clk), .rstN(rstN), .pktDone(pktDone), .pktAckId(pktAckId),
    .pktCrcErr(pktCrcErr), .pktLen(pktLen), .freeBufs(freeBufs),
    .restartIn(restartIn), .ackValid(ackValid), .ackKind(ackKind),
    .ackId(ackId), .ackCause(ackCause), .ackBufs(ackBufs),
    .discardPulse(discardPulse), .errStopped(errStopped), .expAckId(expAckId)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] causeOf(logic [4:0] id, logic [4:0] ex, logic crc, logic [9:0] len);
    if (id != ex) return 2'd1;
    if (crc) return 2'd2;
    if (len > 10'd256) return 2'd3;
    return 2'd0;
  endfunction

  task automatic verifyPending();
    if (pend) begin
      check(eTag, "ackValid", ackValid, eValid);
      check(eTag, "discard", discardPulse, eDisc);
      if (eValid) begin
        check(eTag, "ackKind", ackKind, eKind);
        check(eTag, "ackId", ackId, eId);
        check(eTag, "ackCause", ackCause, eCause);
        check("R9", "ackBufs", ackBufs, eBufs);
      end
      check(eTag, "errStopped", errStopped, mStop);
      check(eTag, "expAckId", expAckId, mExp);
    end
  endtask

  task automatic step(logic d, logic [4:0] id, logic crc, logic [9:0] len,
                      logic [4:0] bufs, logic rs);
    logic [1:0] c;
    @(negedge clk);
    verifyPending();
    pktDone = d; pktAckId = id; pktCrcErr = crc; pktLen = len;
    freeBufs = bufs; restartIn = rs;
    eValid = 0; eDisc = 0; eKind = 0; eCause = 0; eId = 0; eBufs = bufs;
    eTag = rs ? "R8" : "R1";
    c = causeOf(id, mExp, crc, len);
    if (d) begin
      if (mStop) begin
        eDisc = 1; eTag = "R7";
      end else if (c != 0) begin
        eValid = 1; eDisc = 1; eKind = 2; eCause = c; eId = mExp;
        eTag = (c == 1) ? "R4" : (c == 2) ? "R5" : "R6";
      end else if (bufs == 0) begin
        eValid = 1; eDisc = 1; eKind = 1; eId = id; eTag = "R3";
      end else begin
        eValid = 1; eKind = 0; eId = id; eTag = "R2";
      end
    end
    if (mStop) mStop = !rs;
    else if (eValid && eKind == 2) mStop = 1;
    if (eValid && eKind == 0) mExp = mExp + 5'd1;
    pend = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 12345;
    void'($urandom(seed));
    pend = 0; mExp = 0; mStop = 0;
    rstN = 0; pktDone = 0; pktAckId = 0; pktCrcErr = 0; pktLen = 0;
    freeBufs = 5'd4; restartIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", "expAckId", expAckId, 0);
    check("R1", "errStopped", errStopped, 0);
    check("R1", "ackValid", ackValid, 0);
    check("R1", "discard", discardPulse, 0);

    // directed corner cases
    step(1, 0, 0, 10'd256, 5'd7, 0);   // R6 boundary accepted
    step(1, 1, 0, 10'd64, 5'd0, 0);    // R3 retry
    step(1, 1, 0, 10'd257, 5'd3, 0);   // R6 overrun
    step(1, 1, 0, 10'd8, 5'd3, 0);     // R7 discarded
    step(1, 1, 0, 10'd8, 5'd3, 1);     // R8 same-cycle packet discarded
    step(0, 0, 0, 10'd0, 5'd3, 1);     // R8 restart ignored when running
    step(1, 9, 1, 10'd300, 5'd2, 0);   // R5 priority: ackID wins
    step(0, 0, 0, 10'd0, 5'd2, 1);
    step(1, 1, 1, 10'd300, 5'd2, 0);   // R5 CRC beats overrun
    step(0, 0, 0, 10'd0, 5'd2, 1);
    for (int i = 0; i < 40; i++) step(1, mExp, 0, 10'd16, 5'd1, 0);  // R2 wrap

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] id;
      id = ($urandom % 10 < 8) ? mExp : 5'($urandom);
      step(($urandom % 4) != 0, id, ($urandom % 20) == 0,
           ($urandom % 16 == 0) ? 10'(250 + $urandom % 12) : 10'($urandom % 257),
           ($urandom % 8 == 0) ? 5'd0 : 5'($urandom),
           ($urandom % 6) == 0);
    end
    step(0, 0, 0, 10'd0, 5'd1, 0);
    @(negedge clk);
    verifyPending();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule